// File: doc/BRIEF.md
# Speculative Branch History Tracker

This block keeps, for one hardware thread, an ordered queue of the branch predictions that are still in flight. Every prediction leaves a record: its sequence number, its PC, the predicted direction, whether it took its target from the return address stack (with the stack's top index and target saved at that time), and whether it was a call. Records enter at the young end. The queue lives in a circular buffer with full and empty flags.

Three commands act on the queue. Commit retires old records and sends a direction update for each one. Squash drops young records and undoes their side effects: it sends a discard notice to the direction predictor and repairs the return address stack, either by restoring a saved top or by popping the entry a call pushed. Mispredict resolution squashes and then corrects the surviving youngest record. That correction trains the direction predictor with the real outcome, writes the branch target buffer when the branch was taken, and advances two miss counters. The direction predictor, the target buffer and the return stack live outside this block and appear only as output ports.

A walk handles one record per cycle. `busy` stays high until the walk ends. While the block is busy, new inserts and new commands are not accepted, so the source must hold them.

Top module: `bhist_tracker`

## Requirements
- R1: After reset, `q_empty` is 1. `q_full`, `busy`, `ovf_err`, every valid output, and both counters are 0.
- R2: When `ins_valid` is high, `busy` is low and the queue is not full, the record is added at the young end. `q_full` goes high once DEPTH records are held, and `q_empty` shows whether the queue holds any record.
- R3: An insert offered while the queue is full and `busy` is low is dropped. In the following cycle `ovf_err` is high for exactly one cycle, and the queue stays as it was.
- R4: Commit is `cmd_op` = 2'b01. It retires one record per cycle from the old end while the oldest sequence number is at most `cmd_seq`. Each retired record shows `dp_upd_valid` with its PC and predicted direction, and `dp_upd_squashed` = 0.
- R5: Squash is `cmd_op` = 2'b10. It removes one record per cycle from the young end while the youngest sequence number is greater than `cmd_seq`. Each removed record shows `dp_drop_valid` with its sequence number. Sequence numbers compare as unsigned values.
- R6: A removed record that used the return stack shows `ras_restore_valid` with its saved index and target, and no pop.
- R7: A removed record that was a call and did not use the return stack shows `ras_pop_valid` for one cycle. No other cycle shows a restore or a pop.
- R8: Mispredict is `cmd_op` = 2'b11. It first squashes as in R5. If records remain, the youngest one then shows `dp_upd_valid` with its PC, the actual direction `cmd_actual_taken`, and `dp_upd_squashed` = 1, and is removed.
- R9: `btb_wr_valid`, carrying the record's PC and `cmd_target`, is shown only in that correction cycle and only when `cmd_actual_taken` is 1.
- R10: A mispredict that leaves the queue empty after its squash produces no direction update and no target write.
- R11: Each accepted mispredict adds one to `mispred_cnt`. A corrected record that had used the return stack adds one to `ras_mispred_cnt`.
- R12: In the correction cycle, `resolve_seq_err` is 1 exactly when the corrected record's sequence number differs from `cmd_seq`.
- R13: While `busy` is high, `ins_valid` and `cmd_valid` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ins_valid | input | 1 | Offer a new prediction record |
| ins_seq | input | SEQ_W | Record sequence number |
| ins_pc | input | PC_W | Branch PC |
| ins_pred_taken | input | 1 | Predicted direction |
| ins_used_ras | input | 1 | Target came from the return stack |
| ins_ras_idx | input | RIDX_W | Return stack top index saved with the record |
| ins_ras_tgt | input | PC_W | Return stack target saved with the record |
| ins_is_call | input | 1 | Record is a call |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 commit, 10 squash, 11 mispredict |
| cmd_seq | input | SEQ_W | Command sequence bound |
| cmd_actual_taken | input | 1 | Resolved direction (mispredict) |
| cmd_target | input | PC_W | Corrected target (mispredict) |
| busy | output | 1 | Walk in progress |
| q_full | output | 1 | Queue holds DEPTH records |
| q_empty | output | 1 | Queue holds no record |
| ovf_err | output | 1 | Insert dropped because the queue was full |
| dp_upd_valid | output | 1 | Direction update strobe |
| dp_upd_pc | output | PC_W | Direction update PC |
| dp_upd_taken | output | 1 | Direction to train |
| dp_upd_squashed | output | 1 | Update comes from a mispredict |
| dp_drop_valid | output | 1 | Discard notice strobe |
| dp_drop_seq | output | SEQ_W | Sequence number being discarded |
| btb_wr_valid | output | 1 | Target buffer write strobe |
| btb_wr_pc | output | PC_W | Target buffer write PC |
| btb_wr_target | output | PC_W | Target buffer write target |
| ras_restore_valid | output | 1 | Return stack restore strobe |
| ras_restore_idx | output | RIDX_W | Top index to restore |
| ras_restore_tgt | output | PC_W | Target to restore |
| ras_pop_valid | output | 1 | Return stack pop strobe |
| mispred_cnt | output | CNT_W | Mispredict count |
| ras_mispred_cnt | output | CNT_W | Count of corrected records that used the return stack |
| resolve_seq_err | output | 1 | Corrected record's sequence number differs from `cmd_seq` |

## Verification
The hardest case to reach from the ports is a mispredict whose bound falls strictly between two queued sequence numbers. That case shows whether the block stops the squash at the right record and then flags the mismatch on the record that survives. The stimulus table builds gaps into the sequence numbers (40 and 42, then a resolve at 41) and also empties the queue by squash alone, so both the mismatch path and the empty-after-squash path run. A directed test fills the queue to full and forces an overflow. It then injects an insert and a squash in the middle of a commit walk, and the bench's own queue model shows whether either one slipped through.

// File: rtl/bhist_pkg.sv
package bhist_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_COMMIT  = 2'b01,
    OP_SQUASH  = 2'b10,
    OP_MISPRED = 2'b11
  } bh_op_e;

  typedef enum logic [1:0] {
    W_IDLE,
    W_COMMIT,
    W_SQUASH,
    W_RESOLVE
  } bh_walk_e;

endpackage

// File: rtl/bhist_ring.sv
// Circular record store. The old end exposes its low OLD_W bits; the young
// end exposes every bit except bit OLD_W-1, which only the old end needs.
module bhist_ring #(
  parameter int DEPTH = 8,
  parameter int REC_W = 16,
  parameter int OLD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [REC_W-1:0] push_rec,
  input  logic             pop_old,
  input  logic             pop_young,
  output logic [OLD_W-1:0] old_rec,
  output logic [REC_W-2:0] young_rec,
  output logic             full,
  output logic             empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d, young_ptr;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic [REC_W-1:0] mem_q [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  always_comb begin
    young_ptr = ptr_dec(tail_q);
    head_d    = head_q;
    tail_d    = tail_q;
    occ_d     = occ_q;
    if (push)      tail_d = ptr_inc(tail_q);
    if (pop_young) tail_d = young_ptr;
    if (pop_old)   head_d = ptr_inc(head_q);
    case ({push, pop_old | pop_young})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
    end
  end

  // Data array carries no reset; occupancy guards every read.
  always_ff @(posedge clk) begin
    if (push) mem_q[tail_q] <= push_rec;
  end

  assign old_rec   = mem_q[head_q][OLD_W-1:0];
  assign young_rec = {mem_q[young_ptr][REC_W-1:OLD_W], mem_q[young_ptr][OLD_W-2:0]};
  assign empty     = (occ_q == '0);
  assign full      = (occ_q == OCC_W'(DEPTH));

endmodule

// File: rtl/bhist_walker.sv
// Command sequencer: one queue record per cycle, repair/update strobes.
module bhist_walker
  import bhist_pkg::*;
#(
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  parameter int RIDX_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  input  logic [1:0]                         cmd_op,
  input  logic [SEQ_W-1:0]                   cmd_seq,
  input  logic                               cmd_actual_taken,
  input  logic [PC_W-1:0]                    cmd_target,
  input  logic                               q_empty,
  input  logic [SEQ_W+PC_W:0]                old_rec,
  input  logic [SEQ_W+2*PC_W+RIDX_W+1:0]     young_rec,
  output logic                               busy,
  output logic                               pop_old,
  output logic                               pop_young,
  output logic                               dp_upd_valid,
  output logic [PC_W-1:0]                    dp_upd_pc,
  output logic                               dp_upd_taken,
  output logic                               dp_upd_squashed,
  output logic                               dp_drop_valid,
  output logic [SEQ_W-1:0]                   dp_drop_seq,
  output logic                               btb_wr_valid,
  output logic [PC_W-1:0]                    btb_wr_pc,
  output logic [PC_W-1:0]                    btb_wr_target,
  output logic                               ras_restore_valid,
  output logic [RIDX_W-1:0]                  ras_restore_idx,
  output logic [PC_W-1:0]                    ras_restore_tgt,
  output logic                               ras_pop_valid,
  output logic [CNT_W-1:0]                   mispred_cnt,
  output logic [CNT_W-1:0]                   ras_mispred_cnt,
  output logic                               resolve_seq_err
);

  localparam int UR_POS = SEQ_W + PC_W;
  localparam int CL_POS = UR_POS + 1;
  localparam int RI_POS = UR_POS + 2;
  localparam int RT_POS = RI_POS + RIDX_W;

  // Record fields at the two ends
  logic [SEQ_W-1:0]  o_seq, y_seq;
  logic [PC_W-1:0]   o_pc, y_pc, y_rt;
  logic              o_tk, y_ur, y_cl;
  logic [RIDX_W-1:0] y_ri;

  assign o_seq = old_rec[SEQ_W-1:0];
  assign o_pc  = old_rec[SEQ_W +: PC_W];
  assign o_tk  = old_rec[SEQ_W+PC_W];
  assign y_seq = young_rec[SEQ_W-1:0];
  assign y_pc  = young_rec[SEQ_W +: PC_W];
  assign y_ur  = young_rec[UR_POS];
  assign y_cl  = young_rec[CL_POS];
  assign y_ri  = young_rec[RI_POS +: RIDX_W];
  assign y_rt  = young_rec[RT_POS +: PC_W];

  bh_walk_e         state_q, state_d;
  logic [SEQ_W-1:0] bound_q;
  logic             act_q, mp_q;
  logic [PC_W-1:0]  tgt_q;
  logic [CNT_W-1:0] cnt_mp_q, cnt_ras_q;
  logic             accept, ras_hit;
  bh_op_e           op;

  assign op     = bh_op_e'(cmd_op);
  assign accept = cmd_valid && (state_q == W_IDLE) && (op != OP_NONE);
  assign busy   = (state_q != W_IDLE);

  always_comb begin
    state_d           = state_q;
    pop_old           = 1'b0;
    pop_young         = 1'b0;
    dp_upd_valid      = 1'b0;
    dp_upd_pc         = o_pc;
    dp_upd_taken      = o_tk;
    dp_upd_squashed   = 1'b0;
    dp_drop_valid     = 1'b0;
    dp_drop_seq       = y_seq;
    btb_wr_valid      = 1'b0;
    btb_wr_pc         = y_pc;
    btb_wr_target     = tgt_q;
    ras_restore_valid = 1'b0;
    ras_restore_idx   = y_ri;
    ras_restore_tgt   = y_rt;
    ras_pop_valid     = 1'b0;
    resolve_seq_err   = 1'b0;
    ras_hit           = 1'b0;
    case (state_q)
      W_IDLE: begin
        if (accept) state_d = (op == OP_COMMIT) ? W_COMMIT : W_SQUASH;
      end
      W_COMMIT: begin
        if (!q_empty && (o_seq <= bound_q)) begin
          dp_upd_valid = 1'b1;
          pop_old      = 1'b1;
        end else begin
          state_d = W_IDLE;
        end
      end
      W_SQUASH: begin
        if (!q_empty && (y_seq > bound_q)) begin
          dp_drop_valid     = 1'b1;
          ras_restore_valid = y_ur;
          ras_pop_valid     = y_cl && !y_ur;
          pop_young         = 1'b1;
        end else begin
          state_d = mp_q ? W_RESOLVE : W_IDLE;
        end
      end
      W_RESOLVE: begin
        state_d = W_IDLE;
        if (!q_empty) begin
          dp_upd_valid    = 1'b1;
          dp_upd_pc       = y_pc;
          dp_upd_taken    = act_q;
          dp_upd_squashed = 1'b1;
          btb_wr_valid    = act_q;
          resolve_seq_err = (y_seq != bound_q);
          ras_hit         = y_ur;
          pop_young       = 1'b1;
        end
      end
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= W_IDLE;
      bound_q   <= '0;
      act_q     <= 1'b0;
      mp_q      <= 1'b0;
      tgt_q     <= '0;
      cnt_mp_q  <= '0;
      cnt_ras_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        bound_q <= cmd_seq;
        act_q   <= cmd_actual_taken;
        mp_q    <= (op == OP_MISPRED);
        tgt_q   <= cmd_target;
      end
      if (accept && (op == OP_MISPRED)) cnt_mp_q <= cnt_mp_q + 1'b1;
      if (ras_hit) cnt_ras_q <= cnt_ras_q + 1'b1;
    end
  end

  assign mispred_cnt     = cnt_mp_q;
  assign ras_mispred_cnt = cnt_ras_q;

endmodule

// File: rtl/bhist_tracker.sv
module bhist_tracker #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int PC_W   = 32,
  parameter int RIDX_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic              ins_pred_taken,
  input  logic              ins_used_ras,
  input  logic [RIDX_W-1:0] ins_ras_idx,
  input  logic [PC_W-1:0]   ins_ras_tgt,
  input  logic              ins_is_call,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SEQ_W-1:0]  cmd_seq,
  input  logic              cmd_actual_taken,
  input  logic [PC_W-1:0]   cmd_target,
  output logic              busy,
  output logic              q_full,
  output logic              q_empty,
  output logic              ovf_err,
  output logic              dp_upd_valid,
  output logic [PC_W-1:0]   dp_upd_pc,
  output logic              dp_upd_taken,
  output logic              dp_upd_squashed,
  output logic              dp_drop_valid,
  output logic [SEQ_W-1:0]  dp_drop_seq,
  output logic              btb_wr_valid,
  output logic [PC_W-1:0]   btb_wr_pc,
  output logic [PC_W-1:0]   btb_wr_target,
  output logic              ras_restore_valid,
  output logic [RIDX_W-1:0] ras_restore_idx,
  output logic [PC_W-1:0]   ras_restore_tgt,
  output logic              ras_pop_valid,
  output logic [CNT_W-1:0]  mispred_cnt,
  output logic [CNT_W-1:0]  ras_mispred_cnt,
  output logic              resolve_seq_err
);

  // Record layout, LSB first: seq, pc, taken, used_ras, call, ras_idx, ras_tgt
  localparam int OLD_W = SEQ_W + PC_W + 1;
  localparam int REC_W = SEQ_W + 2 * PC_W + RIDX_W + 3;

  logic             push, pop_old, pop_young, ovf_q;
  logic [REC_W-1:0] push_rec;
  logic [OLD_W-1:0] old_rec;
  logic [REC_W-2:0] young_rec;

  assign push     = ins_valid && !busy && !q_full;
  assign push_rec = {ins_ras_tgt, ins_ras_idx, ins_is_call, ins_used_ras,
                     ins_pred_taken, ins_pc, ins_seq};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ins_valid && !busy && q_full;
  end
  assign ovf_err = ovf_q;

  bhist_ring #(
    .DEPTH (DEPTH),
    .REC_W (REC_W),
    .OLD_W (OLD_W)
  ) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_rec  (push_rec),
    .pop_old   (pop_old),
    .pop_young (pop_young),
    .old_rec   (old_rec),
    .young_rec (young_rec),
    .full      (q_full),
    .empty     (q_empty)
  );

  bhist_walker #(
    .SEQ_W  (SEQ_W),
    .PC_W   (PC_W),
    .RIDX_W (RIDX_W),
    .CNT_W  (CNT_W)
  ) u_walk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmd_valid         (cmd_valid),
    .cmd_op            (cmd_op),
    .cmd_seq           (cmd_seq),
    .cmd_actual_taken  (cmd_actual_taken),
    .cmd_target        (cmd_target),
    .q_empty           (q_empty),
    .old_rec           (old_rec),
    .young_rec         (young_rec),
    .busy              (busy),
    .pop_old           (pop_old),
    .pop_young         (pop_young),
    .dp_upd_valid      (dp_upd_valid),
    .dp_upd_pc         (dp_upd_pc),
    .dp_upd_taken      (dp_upd_taken),
    .dp_upd_squashed   (dp_upd_squashed),
    .dp_drop_valid     (dp_drop_valid),
    .dp_drop_seq       (dp_drop_seq),
    .btb_wr_valid      (btb_wr_valid),
    .btb_wr_pc         (btb_wr_pc),
    .btb_wr_target     (btb_wr_target),
    .ras_restore_valid (ras_restore_valid),
    .ras_restore_idx   (ras_restore_idx),
    .ras_restore_tgt   (ras_restore_tgt),
    .ras_pop_valid     (ras_pop_valid),
    .mispred_cnt       (mispred_cnt),
    .ras_mispred_cnt   (ras_mispred_cnt),
    .resolve_seq_err   (resolve_seq_err)
  );

endmodule

// File: rtl/bhist_tracker_chk.sv
module bhist_tracker_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             busy,
  input logic             q_full,
  input logic             q_empty,
  input logic             ovf_err,
  input logic             dp_upd_valid,
  input logic             dp_upd_taken,
  input logic             dp_upd_squashed,
  input logic             dp_drop_valid,
  input logic             btb_wr_valid,
  input logic             ras_restore_valid,
  input logic             ras_pop_valid,
  input logic [CNT_W-1:0] mispred_cnt,
  input logic             resolve_seq_err
);

  a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  a_r3_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> $past(ins_valid && q_full && !busy));

  a_r4_commit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_upd_valid && !dp_upd_squashed) |-> (!dp_drop_valid && !btb_wr_valid));

  a_r5_drop_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_drop_valid |-> busy);

  a_r7_restore_or_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_restore_valid && ras_pop_valid));

  a_r7_repair_needs_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_restore_valid || ras_pop_valid) |-> dp_drop_valid);

  a_r9_btb_taken_only: assert property (@(posedge clk) disable iff (!rst_n)
    btb_wr_valid |-> (dp_upd_valid && dp_upd_squashed && dp_upd_taken));

  a_r11_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mispred_cnt != $past(mispred_cnt)) |->
      ((mispred_cnt == CNT_W'($past(mispred_cnt) + 1'b1)) &&
       $past(cmd_valid && (cmd_op == 2'b11) && !busy)));

  a_r12_err_in_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_seq_err |-> (dp_upd_valid && dp_upd_squashed));

endmodule

bind bhist_tracker bhist_tracker_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/bhist_tracker_tb_top.sv
module bhist_tracker_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic        ins_valid, ins_pred_taken, ins_used_ras, ins_is_call;
  logic [15:0] ins_seq;
  logic [31:0] ins_pc, ins_ras_tgt;
  logic [3:0]  ins_ras_idx;
  logic        cmd_valid, cmd_actual_taken;
  logic [1:0]  cmd_op;
  logic [15:0] cmd_seq;
  logic [31:0] cmd_target;
  logic        busy, q_full, q_empty, ovf_err;
  logic        dp_upd_valid, dp_upd_taken, dp_upd_squashed, dp_drop_valid;
  logic [31:0] dp_upd_pc, btb_wr_pc, btb_wr_target, ras_restore_tgt;
  logic [15:0] dp_drop_seq, mispred_cnt, ras_mispred_cnt;
  logic        btb_wr_valid, ras_restore_valid, ras_pop_valid, resolve_seq_err;
  logic [3:0]  ras_restore_idx;

  bhist_tracker dut_i (.*);

  typedef struct {
    logic [15:0] seq;
    logic [31:0] pc;
    bit          tk, ur, cl;
    logic [3:0]  ri;
    logic [31:0] rt;
  } mrec_t;

  mrec_t mq[$];
  int checks = 0, failures = 0;
  int exp_mp = 0, exp_ras = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  // kind 0 insert, 1 commit, 2 squash, 3 mispredict
  function automatic logic [92:0] mk(input logic [1:0] k, input logic [15:0] s, input logic [31:0] p,
                                     input bit t, input bit u, input bit c, input logic [3:0] ri,
                                     input logic [31:0] tg, input logic [3:0] n);
    return {k, s, p, t, u, c, ri, tg, n};
  endfunction

  localparam int NV = 20;
  localparam logic [92:0] VEC [NV] = '{
    mk(0, 10, 32'h100, 1, 0, 0, 0, 0, 0),
    mk(0, 11, 32'h104, 0, 0, 1, 0, 0, 0),
    mk(0, 12, 32'h108, 1, 1, 0, 3, 32'h500, 0),
    mk(0, 13, 32'h10c, 0, 0, 0, 0, 0, 0),
    mk(1, 10, 0, 0, 0, 0, 0, 0, 1),
    mk(2, 11, 0, 0, 0, 0, 0, 0, 2),
    mk(0, 14, 32'h110, 1, 0, 1, 0, 0, 0),
    mk(0, 15, 32'h114, 0, 0, 0, 0, 0, 0),
    mk(3, 14, 0, 1, 0, 0, 0, 32'h900, 2),
    mk(0, 20, 32'h200, 0, 1, 0, 5, 32'h600, 0),
    mk(3, 20, 0, 0, 0, 0, 0, 0, 1),
    mk(3, 5, 0, 1, 0, 0, 0, 32'hbbb, 1),
    mk(0, 40, 32'h400, 1, 0, 0, 0, 0, 0),
    mk(0, 42, 32'h408, 0, 0, 1, 0, 0, 0),
    mk(3, 41, 0, 1, 0, 0, 0, 32'ha00, 2),
    mk(0, 50, 32'h500, 0, 1, 1, 7, 32'h700, 0),
    mk(0, 51, 32'h504, 1, 0, 0, 0, 0, 0),
    mk(1, 49, 0, 0, 0, 0, 0, 0, 0),
    mk(2, 49, 0, 0, 0, 0, 0, 0, 2),
    mk(1, 16'hffff, 0, 0, 0, 0, 0, 0, 0)
  };

  task automatic do_insert(input logic [15:0] s, input logic [31:0] p, input bit t,
                           input bit u, input bit c, input logic [3:0] ri, input logic [31:0] rt);
    bit was_full;
    mrec_t r;
    was_full = (mq.size() == 8);
    @(negedge clk);
    ins_valid = 1'b1; ins_seq = s; ins_pc = p; ins_pred_taken = t;
    ins_used_ras = u; ins_is_call = c; ins_ras_idx = ri; ins_ras_tgt = rt;
    @(negedge clk);
    ins_valid = 1'b0;
    chk(ovf_err == was_full, "R3 overflow flag", ovf_err, was_full);
    if (!was_full) begin
      r.seq = s; r.pc = p; r.tk = t; r.ur = u; r.cl = c; r.ri = ri; r.rt = rt;
      mq.push_back(r);
    end
    chk(q_full == (mq.size() == 8), "R2 full flag", q_full, mq.size() == 8);
    chk(q_empty == (mq.size() == 0), "R2 empty flag", q_empty, mq.size() == 0);
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [15:0] n, input bit act,
                        input logic [31:0] tg, input int expn, input bit inject);
    int    events = 0, steps = 0;
    bit    exp_res = 0, res_seen = 0;
    mrec_t r;
    foreach (mq[i]) if (mq[i].seq <= n) exp_res = 1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_seq = n; cmd_actual_taken = act; cmd_target = tg;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 2'b11) exp_mp++;
    while (busy && steps < 40) begin
      if (dp_drop_valid) begin
        chk(mq.size() > 0, "R5 drop on empty model", mq.size(), 1);
        if (mq.size() > 0) begin
          r = mq[$];
          chk(dp_drop_seq == r.seq, "R5 drop seq", dp_drop_seq, r.seq);
          chk(ras_restore_valid == r.ur, "R6 restore strobe", ras_restore_valid, r.ur);
          if (r.ur) begin
            chk(ras_restore_idx == r.ri, "R6 restore idx", ras_restore_idx, r.ri);
            chk(ras_restore_tgt == r.rt, "R6 restore tgt", ras_restore_tgt, r.rt);
          end
          chk(ras_pop_valid == (r.cl && !r.ur), "R7 pop strobe", ras_pop_valid, r.cl && !r.ur);
          void'(mq.pop_back());
        end
        events++;
      end else begin
        chk(!ras_restore_valid && !ras_pop_valid, "R7 no stray repair",
            {ras_restore_valid, ras_pop_valid}, 0);
      end
      if (dp_upd_valid && !dp_upd_squashed) begin
        chk(op == 2'b01 && mq.size() > 0, "R4 commit update context", op, 1);
        if (mq.size() > 0) begin
          r = mq[0];
          chk(dp_upd_pc == r.pc, "R4 commit pc", dp_upd_pc, r.pc);
          chk(dp_upd_taken == r.tk, "R4 commit dir", dp_upd_taken, r.tk);
          void'(mq.pop_front());
        end
        events++;
      end
      if (dp_upd_valid && dp_upd_squashed) begin
        chk(op == 2'b11 && mq.size() > 0, "R8 resolve context", op, 3);
        if (mq.size() > 0) begin
          r = mq[$];
          chk(dp_upd_pc == r.pc, "R8 resolve pc", dp_upd_pc, r.pc);
          chk(dp_upd_taken == act, "R8 resolve dir", dp_upd_taken, act);
          chk(btb_wr_valid == act, "R9 btb strobe", btb_wr_valid, act);
          if (act) begin
            chk(btb_wr_pc == r.pc, "R9 btb pc", btb_wr_pc, r.pc);
            chk(btb_wr_target == tg, "R9 btb target", btb_wr_target, tg);
          end
          chk(resolve_seq_err == (r.seq != n), "R12 seq mismatch", resolve_seq_err, r.seq != n);
          if (r.ur) exp_ras++;
          void'(mq.pop_back());
        end
        res_seen = 1;
        events++;
      end
      if (!dp_upd_valid) chk(!btb_wr_valid, "R9 btb outside resolve", btb_wr_valid, 0);
      if (inject && steps == 0) begin
        ins_valid = 1'b1; ins_seq = 16'heeee;
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_seq = 16'd0;
      end else begin
        ins_valid = 1'b0; cmd_valid = 1'b0;
      end
      @(negedge clk);
      steps++;
    end
    ins_valid = 1'b0; cmd_valid = 1'b0;
    chk(events == expn, "R4 R5 R8 event count", events, expn);
    if (op == 2'b01 && mq.size() > 0)
      chk(mq[0].seq > n, "R4 commit stop point", mq[0].seq, n);
    if (op != 2'b01 && mq.size() > 0)
      chk(mq[$].seq <= n, "R5 squash stop point", mq[$].seq, n);
    if (op == 2'b11) begin
      chk(res_seen == exp_res, "R10 resolve presence", res_seen, exp_res);
      chk(mispred_cnt == exp_mp, "R11 mispred count", mispred_cnt, exp_mp);
      chk(ras_mispred_cnt == exp_ras, "R11 ras count", ras_mispred_cnt, exp_ras);
    end
    chk(q_empty == (mq.size() == 0), "R2 empty after walk", q_empty, mq.size() == 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ins_valid = 0; ins_seq = 0; ins_pc = 0; ins_pred_taken = 0; ins_used_ras = 0;
    ins_ras_idx = 0; ins_ras_tgt = 0; ins_is_call = 0;
    cmd_valid = 0; cmd_op = 0; cmd_seq = 0; cmd_actual_taken = 0; cmd_target = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q_empty && !q_full && !busy && !ovf_err, "R1 reset flags",
        {q_empty, q_full, busy, ovf_err}, 4'b1000);
    chk(!dp_upd_valid && !dp_drop_valid && !btb_wr_valid && !ras_restore_valid && !ras_pop_valid,
        "R1 reset strobes", 0, 0);
    chk(mispred_cnt == 0 && ras_mispred_cnt == 0, "R1 reset counters", mispred_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [92:0] v;
      v = VEC[i];
      if (v[92:91] == 2'd0)
        do_insert(v[90:75], v[74:43], v[42], v[41], v[40], v[39:36], v[35:4]);
      else
        do_cmd(v[92:91], v[90:75], v[42], v[35:4], int'(v[3:0]), 1'b0);
    end

    // R2/R3: fill to full, then overflow
    for (int i = 0; i < 8; i++)
      do_insert(16'(100 + i), 32'h1000 + 32'(4 * i), i[0], 0, 0, 0, 0);
    chk(q_full, "R2 full at depth", q_full, 1);
    do_insert(16'd108, 32'h2000, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk(!ovf_err, "R3 overflow one cycle", ovf_err, 0);
    chk(q_full && mq.size() == 8, "R3 queue unchanged", q_full, 1);

    // R13: insert and squash offered mid-walk are ignored
    do_cmd(2'b01, 16'd103, 0, 0, 4, 1'b1);
    chk(!q_full && !q_empty, "R13 four records remain", {q_full, q_empty}, 2'b00);
    do_cmd(2'b01, 16'hffff, 0, 0, 4, 1'b0);
    chk(q_empty, "R13 no extra record", q_empty, 1);

    finish_run();
  end

endmodule